// File: doc/BRIEF.md
# Low-Power Wait and Stop Controller

This block sets the execution state of an 8-bit accumulator-style processor core. It has three run states: normal, waiting and stopped. It decides when the core may advance, and it carries out the sequence that enters an interrupt handler. The core's decode stage sends one-cycle strobes for the wait, stop and software-break instructions. The core also presents its program counter, stack pointer and status byte. The controller returns `run_o`, a stack-push port, a vector-read port and load strobes for the new program counter, status and stack pointer.

A wait instruction halts the core until a hardware interrupt can be taken, and then that interrupt is entered. A stop instruction halts the core more deeply. A takeable hardware interrupt then restarts it through the reset vector, with no pushes and no change to status or stack pointer. Each entry pushes three bytes below the stack pointer in page one. It then reads a little-endian vector word through a read port whose data returns one cycle after the request.

Top module: `lpx_ctrl`

## Requirements
- R1: After reset, `run_o` is 1 and `push_en_o`, `rd_en_o` and `pc_load_o` are 0.
- R2: In normal state with no entry starting, a wait strobe takes the block to waiting. From the next cycle `run_o` is 0 and no push or read occurs until an interrupt is takeable.
- R3: A stop strobe takes the block to stopped, with `run_o` 0. No push or read occurs there, and a masked IRQ (status bit 2 set) does not leave the state.
- R4: When a takeable interrupt arrives in the waiting state, the controller leaves waiting and performs a full interrupt entry. `run_o` returns to 1 in the cycle after the load.
- R5: When a takeable interrupt arrives in the stopped state, the controller reads 0xFFFC and then 0xFFFD and loads the PC from them. It makes no push and does not assert the status or stack-pointer loads.
- R6: An entry pushes, in successive cycles, the PC high byte to address {0x01, sp}, the PC low byte to {0x01, sp-1} and the status byte to {0x01, sp-2}, all modulo 256 within the page. It then loads sp-3.
- R7: A hardware entry pushes `pc_i` as it was at the trigger. A software break pushes `pc_i`+1, wrapping modulo 2^16.
- R8: In the pushed status, bit 4 is 1 only for a software break, and bit 5 is always 1. The other bits are copied from `status_i`.
- R9: The loaded status is `status_i` with bit 2 (interrupt disable) set and bit 3 (decimal) cleared.
- R10: The vector word is read low byte first, from 0xFFFA/0xFFFB for NMI and from 0xFFFE/0xFFFF for IRQ and break. The new PC is loaded in the cycle after the high-byte read.
- R11: IRQ is a level and is taken only while status bit 2 is 0. NMI is taken once per rising edge of `nmi_i`, whatever bit 2 is, and wins over IRQ in the same cycle.
- R12: `soft_rst_i` returns the block to normal and idle from any state, aborting any entry in progress. `run_o` is 1 in the next cycle.
- R13: A takeable hardware interrupt wins over a break strobe in the same cycle, so no increment and bit 4 clear. A stop strobe wins over a wait strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous return to normal |
| wai_op_i | input | 1 | Wait instruction strobe |
| stp_op_i | input | 1 | Stop instruction strobe |
| brk_op_i | input | 1 | Software break strobe |
| irq_i | input | 1 | Maskable interrupt request, level |
| nmi_i | input | 1 | Non-maskable interrupt, rising edge |
| pc_i | input | 16 | Current program counter |
| sp_i | input | 8 | Current stack pointer |
| status_i | input | 8 | Current status byte (bit 2 I, bit 3 D) |
| rd_data_i | input | 8 | Read data, one cycle after request |
| run_o | output | 1 | Core may advance |
| push_en_o | output | 1 | Stack write request |
| push_addr_o | output | 16 | Stack write address |
| push_data_o | output | 8 | Stack write data |
| rd_en_o | output | 1 | Vector read request |
| rd_addr_o | output | 16 | Vector read address |
| pc_load_o | output | 1 | Load new program counter |
| pc_o | output | 16 | New program counter |
| status_load_o | output | 1 | Load updated status |
| status_o | output | 8 | Updated status |
| sp_load_o | output | 1 | Load updated stack pointer |
| sp_o | output | 8 | Updated stack pointer |

## Verification
The hardest conditions to reach are the wake-up paths. Each needs a halting instruction to be accepted first, and then an interrupt that is held back by the mask before the mask is lifted. The stimulus sends the wait or stop strobe, holds IRQ high with status bit 2 set for several cycles to show the block stays halted, and then clears bit 2 so the entry or the reset-vector restart begins. Simultaneous strobes (stop with wait, IRQ with break, NMI with IRQ) and a soft reset in the middle of a push sequence cover the priority and abort corners.

// File: rtl/lpx_pkg.sv
package lpx_pkg;
  typedef enum logic [1:0] {RUN_NORMAL, RUN_WAIT, RUN_STOP} run_state_e;
  typedef enum logic [1:0] {ENT_HW, ENT_SW, ENT_RESTART} entry_kind_e;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_PUSH_HI, SQ_PUSH_LO, SQ_PUSH_ST, SQ_VEC_LO, SQ_VEC_HI, SQ_LOAD
  } seq_step_e;

  localparam int unsigned ST_IRQ_OFF = 2;
  localparam int unsigned ST_DEC     = 3;
  localparam int unsigned ST_BRK     = 4;
  localparam int unsigned ST_ONE     = 5;
endpackage

// File: rtl/lpx_int_sel.sv
module lpx_int_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic irq_i,
  input  logic nmi_i,
  input  logic irq_mask_i,
  input  logic clr_nmi_i,
  output logic req_o,
  output logic nmi_sel_o
);
  logic nmi_q, pend_q, nmi_edge, nmi_hit;

  assign nmi_edge  = nmi_i & ~nmi_q;
  assign nmi_hit   = pend_q | nmi_edge;
  assign nmi_sel_o = nmi_hit;
  assign req_o     = nmi_hit | (irq_i & ~irq_mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      nmi_q <= nmi_i;
      if (soft_rst_i) pend_q <= 1'b0;
      else            pend_q <= nmi_hit & ~clr_nmi_i;
    end
  end
endmodule

// File: rtl/lpx_run_fsm.sv
module lpx_run_fsm
  import lpx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       soft_rst_i,
  input  logic       wai_i,
  input  logic       stp_i,
  input  logic       brk_i,
  input  logic       hw_req_i,
  input  logic       busy_i,
  output run_state_e state_o
);
  run_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RUN_NORMAL:
        if (!busy_i && !hw_req_i && !brk_i) begin
          if (stp_i)      state_d = RUN_STOP;
          else if (wai_i) state_d = RUN_WAIT;
        end
      RUN_WAIT, RUN_STOP:
        if (hw_req_i) state_d = RUN_NORMAL;
      default: state_d = RUN_NORMAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         state_q <= RUN_NORMAL;
    else if (soft_rst_i) state_q <= RUN_NORMAL;
    else                 state_q <= state_d;
  end

  assign state_o = state_q;

  // R2
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RUN_WAIT && !hw_req_i && !soft_rst_i) |=> state_q == RUN_WAIT);
  // R3
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RUN_STOP && !hw_req_i && !soft_rst_i) |=> state_q == RUN_STOP);
endmodule

// File: rtl/lpx_entry_seq.sv
module lpx_entry_seq
  import lpx_pkg::*;
#(
  parameter int unsigned    AW         = 16,
  parameter int unsigned    DW         = 8,
  parameter logic [DW-1:0]  STACK_PAGE = 8'h01,
  parameter logic [AW-1:0]  NMI_VEC    = 16'hFFFA,
  parameter logic [AW-1:0]  RST_VEC    = 16'hFFFC,
  parameter logic [AW-1:0]  IRQ_VEC    = 16'hFFFE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic          start_i,
  input  entry_kind_e   kind_i,
  input  logic          nmi_sel_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] status_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          push_en_o,
  output logic [AW-1:0] push_addr_o,
  output logic [DW-1:0] push_data_o,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          pc_load_o,
  output logic [AW-1:0] pc_o,
  output logic          status_load_o,
  output logic [DW-1:0] status_o,
  output logic          sp_load_o,
  output logic [DW-1:0] sp_o
);
  localparam logic [DW-1:0] MASK_I   = DW'(1) << ST_IRQ_OFF;
  localparam logic [DW-1:0] MASK_D   = DW'(1) << ST_DEC;
  localparam logic [DW-1:0] MASK_B   = DW'(1) << ST_BRK;
  localparam logic [DW-1:0] MASK_ONE = DW'(1) << ST_ONE;

  seq_step_e     step_q;
  entry_kind_e   kind_q;
  logic [AW-1:0] ret_q, vec_q;
  logic [DW-1:0] stat_q, sp_q, lo_q;
  logic [DW-1:0] push_off;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= SQ_IDLE;
      kind_q <= ENT_HW;
      ret_q  <= '0;
      vec_q  <= '0;
      stat_q <= '0;
      sp_q   <= '0;
      lo_q   <= '0;
    end else if (soft_rst_i) begin
      step_q <= SQ_IDLE;
    end else begin
      unique case (step_q)
        SQ_IDLE:
          if (start_i) begin
            kind_q <= kind_i;
            ret_q  <= (kind_i == ENT_SW) ? pc_i + AW'(1) : pc_i;
            stat_q <= status_i;
            sp_q   <= sp_i;
            vec_q  <= (kind_i == ENT_RESTART) ? RST_VEC : (nmi_sel_i ? NMI_VEC : IRQ_VEC);
            step_q <= (kind_i == ENT_RESTART) ? SQ_VEC_LO : SQ_PUSH_HI;
          end
        SQ_PUSH_HI: step_q <= SQ_PUSH_LO;
        SQ_PUSH_LO: step_q <= SQ_PUSH_ST;
        SQ_PUSH_ST: step_q <= SQ_VEC_LO;
        SQ_VEC_LO:  step_q <= SQ_VEC_HI;
        SQ_VEC_HI: begin
          lo_q   <= rd_data_i;
          step_q <= SQ_LOAD;
        end
        default:    step_q <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    push_off    = '0;
    push_data_o = ret_q[AW-1:DW];
    unique case (step_q)
      SQ_PUSH_LO: begin
        push_off    = DW'(1);
        push_data_o = ret_q[DW-1:0];
      end
      SQ_PUSH_ST: begin
        push_off    = DW'(2);
        push_data_o = (stat_q & ~MASK_B) | MASK_ONE | ((kind_q == ENT_SW) ? MASK_B : '0);
      end
      default: ;
    endcase
  end

  assign busy_o        = step_q != SQ_IDLE;
  assign push_en_o     = step_q inside {SQ_PUSH_HI, SQ_PUSH_LO, SQ_PUSH_ST};
  assign push_addr_o   = {STACK_PAGE, sp_q - push_off};
  assign rd_en_o       = step_q inside {SQ_VEC_LO, SQ_VEC_HI};
  assign rd_addr_o     = vec_q + AW'(step_q == SQ_VEC_HI);
  assign pc_load_o     = step_q == SQ_LOAD;
  assign pc_o          = {rd_data_i, lo_q};
  assign status_load_o = pc_load_o && kind_q != ENT_RESTART;
  assign status_o      = (stat_q | MASK_I) & ~MASK_D;
  assign sp_load_o     = status_load_o;
  assign sp_o          = sp_q - DW'(3);

  // R6
  push_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_en_o && $past(push_en_o)) |->
      push_addr_o[DW-1:0] == $past(push_addr_o[DW-1:0]) - DW'(1));
  // R10
  vec_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && $past(rd_en_o)) |-> rd_addr_o == $past(rd_addr_o) + AW'(1));
  // R10
  load_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |-> $past(rd_en_o));
endmodule

// File: rtl/lpx_ctrl.sv
module lpx_ctrl
  import lpx_pkg::*;
#(
  parameter int unsigned   AW         = 16,
  parameter int unsigned   DW         = 8,
  parameter logic [DW-1:0] STACK_PAGE = 8'h01,
  parameter logic [AW-1:0] NMI_VEC    = 16'hFFFA,
  parameter logic [AW-1:0] RST_VEC    = 16'hFFFC,
  parameter logic [AW-1:0] IRQ_VEC    = 16'hFFFE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic          wai_op_i,
  input  logic          stp_op_i,
  input  logic          brk_op_i,
  input  logic          irq_i,
  input  logic          nmi_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] sp_i,
  input  logic [DW-1:0] status_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          run_o,
  output logic          push_en_o,
  output logic [AW-1:0] push_addr_o,
  output logic [DW-1:0] push_data_o,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          pc_load_o,
  output logic [AW-1:0] pc_o,
  output logic          status_load_o,
  output logic [DW-1:0] status_o,
  output logic          sp_load_o,
  output logic [DW-1:0] sp_o
);
  run_state_e  state;
  entry_kind_e kind;
  logic hw_req, nmi_sel, busy;
  logic start_hw, start_sw, start_rst, seq_start, clr_nmi;

  assign start_hw  = hw_req && !busy && (state == RUN_NORMAL || state == RUN_WAIT);
  assign start_rst = hw_req && state == RUN_STOP;
  assign start_sw  = brk_op_i && !busy && !hw_req && state == RUN_NORMAL;
  assign seq_start = start_hw | start_rst | start_sw;
  assign kind      = start_rst ? ENT_RESTART : (start_hw ? ENT_HW : ENT_SW);
  assign clr_nmi   = (start_hw | start_rst) & nmi_sel;
  assign run_o     = state == RUN_NORMAL && !busy;

  lpx_int_sel u_int_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .irq_i      (irq_i),
    .nmi_i      (nmi_i),
    .irq_mask_i (status_i[ST_IRQ_OFF]),
    .clr_nmi_i  (clr_nmi),
    .req_o      (hw_req),
    .nmi_sel_o  (nmi_sel)
  );

  lpx_run_fsm u_run_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .wai_i      (wai_op_i),
    .stp_i      (stp_op_i),
    .brk_i      (brk_op_i),
    .hw_req_i   (hw_req),
    .busy_i     (busy),
    .state_o    (state)
  );

  lpx_entry_seq #(
    .AW(AW), .DW(DW), .STACK_PAGE(STACK_PAGE),
    .NMI_VEC(NMI_VEC), .RST_VEC(RST_VEC), .IRQ_VEC(IRQ_VEC)
  ) u_entry_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .soft_rst_i    (soft_rst_i),
    .start_i       (seq_start),
    .kind_i        (kind),
    .nmi_sel_i     (nmi_sel),
    .pc_i          (pc_i),
    .sp_i          (sp_i),
    .status_i      (status_i),
    .rd_data_i     (rd_data_i),
    .busy_o        (busy),
    .push_en_o     (push_en_o),
    .push_addr_o   (push_addr_o),
    .push_data_o   (push_data_o),
    .rd_en_o       (rd_en_o),
    .rd_addr_o     (rd_addr_o),
    .pc_load_o     (pc_load_o),
    .pc_o          (pc_o),
    .status_load_o (status_load_o),
    .status_o      (status_o),
    .sp_load_o     (sp_load_o),
    .sp_o          (sp_o)
  );

  // R3
  stop_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == RUN_STOP |-> (!push_en_o && !rd_en_o));
  // R12
  soft_rst_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> run_o);
  // R2
  halted_no_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == RUN_NORMAL && !busy && !hw_req && !brk_op_i && (wai_op_i || stp_op_i)
     && !soft_rst_i) |=> !run_o);
endmodule

// File: tb/lpx_ctrl_bench.sv
module lpx_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0;
  logic wai = 1'b0, stp = 1'b0, brk = 1'b0, irq = 1'b0, nmi = 1'b0;
  logic [15:0] pc = '0;
  logic [7:0]  sp = '0, st = '0, rd_data = '0;
  logic run, push_en, rd_en, pc_load, st_load, sp_load;
  logic [15:0] push_addr, rd_addr, pc_out;
  logic [7:0]  push_data, st_out, sp_out;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpx_ctrl u_lpx_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst),
    .wai_op_i(wai), .stp_op_i(stp), .brk_op_i(brk), .irq_i(irq), .nmi_i(nmi),
    .pc_i(pc), .sp_i(sp), .status_i(st), .rd_data_i(rd_data),
    .run_o(run), .push_en_o(push_en), .push_addr_o(push_addr), .push_data_o(push_data),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .pc_load_o(pc_load), .pc_o(pc_out),
    .status_load_o(st_load), .status_o(st_out), .sp_load_o(sp_load), .sp_o(sp_out)
  );

  function automatic logic [7:0] vec_byte(input logic [15:0] a);
    case (a)
      16'hFFFA: return 8'h11;
      16'hFFFB: return 8'h22;
      16'hFFFC: return 8'h33;
      16'hFFFD: return 8'h44;
      16'hFFFE: return 8'h55;
      16'hFFFF: return 8'h66;
      default:  return 8'hA5;
    endcase
  endfunction

  always_ff @(posedge clk) if (rd_en) rd_data <= vec_byte(rd_addr);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // kind: 0 IRQ, 1 NMI, 2 BRK; trigger already driven before the coming edge
  task automatic follow_entry(input logic [1:0] kind, input logic [15:0] p,
                              input logic [7:0] s, input logic [7:0] t);
    logic [15:0] ret, vec;
    logic [7:0]  pst;
    ret = (kind == 2) ? p + 16'd1 : p;
    vec = (kind == 1) ? 16'hFFFA : 16'hFFFE;
    pst = (t & ~8'h10) | 8'h20 | ((kind == 2) ? 8'h10 : 8'h00);
    @(negedge clk); irq = 0; brk = 0;
    check("R6 push1 en", push_en, 1);
    check("R6 push1 addr", push_addr, {8'h01, s});
    check("R7 push1 data", push_data, ret[15:8]);
    check("R4 run low", run, 0);
    @(negedge clk);
    check("R6 push2 addr", push_addr, {8'h01, s - 8'd1});
    check("R7 push2 data", push_data, ret[7:0]);
    @(negedge clk);
    check("R6 push3 addr", push_addr, {8'h01, s - 8'd2});
    check("R8 push status", push_data, pst);
    @(negedge clk);
    check("R10 vec lo", {rd_en, push_en, rd_addr}, {2'b10, vec});
    @(negedge clk);
    check("R10 vec hi", {rd_en, rd_addr}, {1'b1, vec + 16'd1});
    @(negedge clk);
    check("R10 pc load", {pc_load, pc_out}, {1'b1, vec_byte(vec + 16'd1), vec_byte(vec)});
    check("R9 status", {st_load, st_out}, {1'b1, (t | 8'h04) & ~8'h08});
    check("R6 sp load", {sp_load, sp_out}, {1'b1, s - 8'd3});
    @(negedge clk);
    check("R4 run back", run, 1);
  endtask

  localparam logic [33:0] TBL [6] = '{
    {2'd0, 16'h1234, 8'hFF, 8'hC3},
    {2'd1, 16'hABCD, 8'h80, 8'h0C},
    {2'd2, 16'h2000, 8'h10, 8'h08},
    {2'd2, 16'hFFFF, 8'h02, 8'h00},
    {2'd0, 16'h00FF, 8'h00, 8'h31},
    {2'd1, 16'h8000, 8'h40, 8'h04}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check("R1 reset run", run, 1);
    check("R1 reset idle", {push_en, rd_en, pc_load}, 3'b000);

    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      pc = TBL[i][31:16]; sp = TBL[i][15:8]; st = TBL[i][7:0];
      case (TBL[i][33:32])
        2'd0: irq = 1;
        2'd1: nmi = 1;
        default: brk = 1;
      endcase
      follow_entry(TBL[i][33:32], TBL[i][31:16], TBL[i][15:8], TBL[i][7:0]);
      if (TBL[i][33:32] == 2'd1) begin
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          check("R11 nmi once", {run, push_en}, 2'b10);
        end
        nmi = 0;
      end
    end

    // R11 masked IRQ ignored in normal
    @(negedge clk); st = 8'h04; irq = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R11 masked irq", {run, push_en}, 2'b10);
    end
    irq = 0;

    // R11 NMI beats IRQ
    @(negedge clk); st = 8'h00; pc = 16'h4242; sp = 8'hF0; irq = 1; nmi = 1;
    follow_entry(2'd1, 16'h4242, 8'hF0, 8'h00);
    nmi = 0;

    // R13 IRQ beats BRK
    @(negedge clk); st = 8'h00; pc = 16'h1000; sp = 8'hE0; irq = 1; brk = 1;
    follow_entry(2'd0, 16'h1000, 8'hE0, 8'h00);

    // R2 wait, R4 wake
    @(negedge clk); wai = 1;
    @(negedge clk); wai = 0;
    check("R2 wait run", run, 0);
    st = 8'h04; irq = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R2 wait quiet", {run, push_en, rd_en}, 3'b000);
    end
    st = 8'h00; pc = 16'h0300; sp = 8'hC0;
    follow_entry(2'd0, 16'h0300, 8'hC0, 8'h00);

    // R13 STP beats WAI, R3 stop, R5 restart
    @(negedge clk); wai = 1; stp = 1;
    @(negedge clk); wai = 0; stp = 0;
    st = 8'h04; irq = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R3 stopped quiet", {run, push_en, rd_en}, 3'b000);
    end
    st = 8'h00;
    @(negedge clk); irq = 0;
    check("R5 R13 rst vec lo", {rd_en, push_en, rd_addr}, {2'b10, 16'hFFFC});
    @(negedge clk);
    check("R5 rst vec hi", {rd_en, rd_addr}, {1'b1, 16'hFFFD});
    @(negedge clk);
    check("R5 restart pc", {pc_load, pc_out}, {1'b1, 16'h4433});
    check("R5 no st/sp load", {st_load, sp_load}, 2'b00);
    @(negedge clk);
    check("R5 run back", run, 1);

    // R12 soft reset from stop and from wait
    @(negedge clk); stp = 1;
    @(negedge clk); stp = 0;
    check("R12 stopped", run, 0);
    soft_rst = 1;
    @(negedge clk); soft_rst = 0;
    check("R12 from stop", run, 1);
    wai = 1;
    @(negedge clk); wai = 0;
    check("R12 waiting", run, 0);
    soft_rst = 1;
    @(negedge clk); soft_rst = 0;
    check("R12 from wait", run, 1);

    // R12 abort mid-entry
    st = 8'h00; irq = 1;
    @(negedge clk); irq = 0;
    check("R12 entry begun", push_en, 1);
    soft_rst = 1;
    @(negedge clk); soft_rst = 0;
    check("R12 abort", {run, push_en, rd_en}, 3'b100);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule